// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects hardware event pulses into sticky status bits held in five secondary status registers and one primary status register, and reduces them to a single interrupt line. Most event sources are per transmit queue: each secondary register holds one or two per-queue fields. A few events, such as host-bus faults and beacon-timing events, are individual causes. Each summary bit of the primary register is not stored. It is the live OR of one group of secondary bits. Software reads the primary register to find which group fired, reads the matching secondary register to find the queue or cause, and then clears the bits it handled with write-one-to-clear accesses.

A primary mask, a secondary mask that covers only the host-error and beacon causes, and a one-bit global enable combine the status into the interrupt output. Writing a summary bit of the primary register clears the whole secondary group behind it in one access. Clearing the secondary bits directly makes the summary bit fall by itself. A small set of direct events is stored in the primary register itself, above the summary bits.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every status register, both mask registers and the global enable read as zero, and `irq` is low. Register addresses: 0 primary, 1 to 5 secondary 0 to 4, 6 primary mask, 7 secondary mask, 8 global enable. Any other address reads zero.
- R2: An event pulse sets its secondary bit on the next clock edge, and the bit stays set until it is cleared. Queue q sits at these positions: transmit-done at secondary 0 bit q; descriptor-done at secondary 0 bit 16+q; transmit-error at secondary 1 bit q; end-of-list at secondary 1 bit 16+q; underrun at secondary 2 bit q; rate overrun at secondary 3 bit q; rate underrun at secondary 3 bit 16+q; queue-trigger at secondary 4 bit q. Host causes (master abort, system error, parity) sit at secondary 2 bits 16 to 18. Beacon causes (tim, cab-end, dtim-sync, beacon-timeout, cab-timeout, dtim) sit at secondary 2 bits 20 to 25.
- R3: A write to a secondary register clears exactly the bits written as one and leaves all other bits unchanged.
- R4: Primary bits 0 to 9 are live ORs, in this order: transmit-done, descriptor-done, transmit-error, end-of-list, underrun, host-error, beacon, rate overrun, rate underrun, queue-trigger. When the group's secondary bits are cleared, the summary bit falls with no write to the primary register.
- R5: Writing a one to a primary summary bit clears every secondary bit of that group. Other groups are left unchanged.
- R6: Direct event j sets primary bit 10+j, which is sticky and is cleared by write-one-to-clear at that position.
- R7: The host-error and beacon summary bits count only the causes enabled in the secondary mask. Mask bits 0 to 2 cover the host causes and bits 3 to 8 cover the beacon causes, each in the order given in R2. The secondary status bits are set whatever the mask holds.
- R8: `irq` is high exactly when the global enable (bit 0 at address 8) is set and the primary status ANDed with the primary mask is nonzero.
- R9: When an event and a clear (direct or by group) hit the same bit in the same cycle, the event wins and the bit stays set.
- R10: The mask and enable registers read back the written value, limited to their widths: primary-mask width, 9 bits, and 1 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| ev_txok | input | NQ | Per-queue transmit-done events |
| ev_txdesc | input | NQ | Per-queue descriptor-done events |
| ev_txerr | input | NQ | Per-queue transmit-error events |
| ev_eol | input | NQ | Per-queue end-of-list events |
| ev_urn | input | NQ | Per-queue underrun events |
| ev_cbro | input | NQ | Per-queue rate-overrun events |
| ev_cbru | input | NQ | Per-queue rate-underrun events |
| ev_qtrig | input | NQ | Per-queue trigger events |
| ev_host | input | 3 | Master abort, system error, parity error |
| ev_bcn | input | 6 | Beacon-timing causes |
| ev_direct | input | ND | Events stored directly in the primary register |
| irq | output | 1 | Interrupt request |

## Verification
A hardware event and a software clear can fall in the same cycle. The clear can be a direct write-one-to-clear to a secondary register or a group clear through a primary summary bit. The bench provokes this by raising an event pulse on the same clock edge as the clearing write. It judges the result by reading the register afterwards: the event's bit must still be set, and the other bits named in the write must be gone. The live summary is judged the same way: after the secondary bits are cleared, the primary bit must fall without any access to the primary register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int ADDR_W   = 4;
   localparam int HI_OFF   = 16;  // second per-queue field in a secondary register
   localparam int HOST_OFF = 16;
   localparam int BCN_OFF  = 20;
   localparam int N_HOST   = 3;
   localparam int N_BCN    = 6;
   localparam int N_SMASK  = N_HOST + N_BCN;
   localparam int N_SUM    = 10;  // summary bits at the bottom of the primary register
   localparam int N_QGRP   = 8;   // per-queue groups
   localparam int N_SEC    = 5;

   typedef enum logic [ADDR_W-1:0] {
      A_PRIM  = 4'd0,
      A_SEC0  = 4'd1,
      A_SEC1  = 4'd2,
      A_SEC2  = 4'd3,
      A_SEC3  = 4'd4,
      A_SEC4  = 4'd5,
      A_PMASK = 4'd6,
      A_SMASK = 4'd7,
      A_GEN   = 4'd8
   } reg_addr_e;

   localparam int P_TXOK = 0, P_TXDESC = 1, P_TXERR = 2, P_EOL = 3, P_URN = 4,
                  P_HOST = 5, P_BCN = 6, P_CBRO = 7, P_CBRU = 8, P_QTRIG = 9;

   // primary position of per-queue group g (0..7)
   function automatic int grp_pos(input int g);
      return (g < 5) ? g : g + 2;
   endfunction
endpackage

// File: rtl/irq_sticky_reg.sv
module irq_sticky_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   // set dominates a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/irq_clear_map.sv
module irq_clear_map
   import irq_agg_pkg::*;
#(
   parameter int NQ = 10,
   parameter int DW = 32,
   parameter int ND = 6
) (
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DW-1:0]            wdata,
   output logic [N_SEC-1:0][DW-1:0] sec_clr,
   output logic [ND-1:0]            dir_clr
);
   always_comb begin
      sec_clr = '0;
      dir_clr = '0;
      if (wr_en) begin
         for (int k = 0; k < N_SEC; k++)
            if (addr == ADDR_W'(k + 1)) sec_clr[k] = wdata;
         if (addr == A_PRIM) begin
            if (wdata[P_TXOK])   sec_clr[0][0      +: NQ] = '1;
            if (wdata[P_TXDESC]) sec_clr[0][HI_OFF +: NQ] = '1;
            if (wdata[P_TXERR])  sec_clr[1][0      +: NQ] = '1;
            if (wdata[P_EOL])    sec_clr[1][HI_OFF +: NQ] = '1;
            if (wdata[P_URN])    sec_clr[2][0      +: NQ] = '1;
            if (wdata[P_HOST])   sec_clr[2][HOST_OFF +: N_HOST] = '1;
            if (wdata[P_BCN])    sec_clr[2][BCN_OFF  +: N_BCN]  = '1;
            if (wdata[P_CBRO])   sec_clr[3][0      +: NQ] = '1;
            if (wdata[P_CBRU])   sec_clr[3][HI_OFF +: NQ] = '1;
            if (wdata[P_QTRIG])  sec_clr[4][0      +: NQ] = '1;
            dir_clr = wdata[N_SUM +: ND];
         end
      end
   end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
   import irq_agg_pkg::*;
#(
   parameter int NQ = 10,
   parameter int ND = 6,
   parameter int PW = N_SUM + ND
) (
   input  logic [N_QGRP-1:0][NQ-1:0] qfld,
   input  logic [N_HOST-1:0]         host_q,
   input  logic [N_BCN-1:0]          bcn_q,
   input  logic [N_SMASK-1:0]        smask,
   input  logic [ND-1:0]             dir_q,
   output logic [PW-1:0]             prim
);
   for (genvar g = 0; g < N_QGRP; g++) begin : g_qsum
      assign prim[grp_pos(g)] = |qfld[g];
   end
   assign prim[P_HOST]       = |(host_q & smask[0 +: N_HOST]);
   assign prim[P_BCN]        = |(bcn_q  & smask[N_HOST +: N_BCN]);
   assign prim[N_SUM +: ND]  = dir_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int NQ = 10,
   parameter int DW = 32,
   parameter int ND = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [NQ-1:0]     ev_txok,
   input  logic [NQ-1:0]     ev_txdesc,
   input  logic [NQ-1:0]     ev_txerr,
   input  logic [NQ-1:0]     ev_eol,
   input  logic [NQ-1:0]     ev_urn,
   input  logic [NQ-1:0]     ev_cbro,
   input  logic [NQ-1:0]     ev_cbru,
   input  logic [NQ-1:0]     ev_qtrig,
   input  logic [N_HOST-1:0] ev_host,
   input  logic [N_BCN-1:0]  ev_bcn,
   input  logic [ND-1:0]     ev_direct,
   output logic              irq
);
   localparam int PW = N_SUM + ND;

   if (NQ < 1 || NQ > HI_OFF) begin : g_bad_nq
      $error("NQ must lie in 1..16");
   end
   if (DW < HI_OFF + NQ || DW < BCN_OFF + N_BCN || DW < PW) begin : g_bad_dw
      $error("DW too narrow for the register layout");
   end

   logic [N_SEC-1:0][DW-1:0] sec_set, sec_clr, sec_q;
   logic [ND-1:0]            dir_clr, dir_q;
   logic [N_QGRP-1:0][NQ-1:0] qfld;
   logic [PW-1:0]            prim, pmask_q;
   logic [N_SMASK-1:0]       smask_q;
   logic                     gen_q;

   always_comb begin
      sec_set = '0;
      sec_set[0][0 +: NQ]             = ev_txok;
      sec_set[0][HI_OFF +: NQ]        = ev_txdesc;
      sec_set[1][0 +: NQ]             = ev_txerr;
      sec_set[1][HI_OFF +: NQ]        = ev_eol;
      sec_set[2][0 +: NQ]             = ev_urn;
      sec_set[2][HOST_OFF +: N_HOST]  = ev_host;
      sec_set[2][BCN_OFF +: N_BCN]    = ev_bcn;
      sec_set[3][0 +: NQ]             = ev_cbro;
      sec_set[3][HI_OFF +: NQ]        = ev_cbru;
      sec_set[4][0 +: NQ]             = ev_qtrig;
   end

   irq_clear_map #(.NQ(NQ), .DW(DW), .ND(ND)) u_clr (
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .sec_clr(sec_clr), .dir_clr(dir_clr)
   );

   for (genvar k = 0; k < N_SEC; k++) begin : g_sec
      irq_sticky_reg #(.W(DW)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .set(sec_set[k]), .clr(sec_clr[k]), .q(sec_q[k])
      );
   end

   irq_sticky_reg #(.W(ND)) u_dir (
      .clk(clk), .rst_n(rst_n), .set(ev_direct), .clr(dir_clr), .q(dir_q)
   );

   assign qfld[0] = sec_q[0][0 +: NQ];
   assign qfld[1] = sec_q[0][HI_OFF +: NQ];
   assign qfld[2] = sec_q[1][0 +: NQ];
   assign qfld[3] = sec_q[1][HI_OFF +: NQ];
   assign qfld[4] = sec_q[2][0 +: NQ];
   assign qfld[5] = sec_q[3][0 +: NQ];
   assign qfld[6] = sec_q[3][HI_OFF +: NQ];
   assign qfld[7] = sec_q[4][0 +: NQ];

   irq_summary #(.NQ(NQ), .ND(ND), .PW(PW)) u_sum (
      .qfld(qfld),
      .host_q(sec_q[2][HOST_OFF +: N_HOST]),
      .bcn_q(sec_q[2][BCN_OFF +: N_BCN]),
      .smask(smask_q), .dir_q(dir_q), .prim(prim)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pmask_q <= '0;
         smask_q <= '0;
         gen_q   <= 1'b0;
      end else if (wr_en) begin
         if (addr == A_PMASK) pmask_q <= wdata[PW-1:0];
         if (addr == A_SMASK) smask_q <= wdata[N_SMASK-1:0];
         if (addr == A_GEN)   gen_q   <= wdata[0];
      end
   end

   always_comb begin
      case (addr)
         A_PRIM:  rdata = DW'(prim);
         A_SEC0:  rdata = sec_q[0];
         A_SEC1:  rdata = sec_q[1];
         A_SEC2:  rdata = sec_q[2];
         A_SEC3:  rdata = sec_q[3];
         A_SEC4:  rdata = sec_q[4];
         A_PMASK: rdata = DW'(pmask_q);
         A_SMASK: rdata = DW'(smask_q);
         A_GEN:   rdata = DW'(gen_q);
         default: rdata = '0;
      endcase
   end

   assign irq = gen_q & (|(prim & pmask_q));
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
   import irq_agg_pkg::*;
#(
   parameter int NQ = 10,
   parameter int PW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [NQ-1:0]     wd_lo,
   input logic [NQ-1:0]     ev_txok,
   input logic [NQ-1:0]     txok_q,
   input logic [PW-1:0]     prim,
   input logic [PW-1:0]     pmask_q,
   input logic              gen_q,
   input logic              irq
);
   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_q |-> !irq);
   // R8
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (|(prim & pmask_q)));
   // R9
   evt_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_txok[0] |=> txok_q[0]);
   // R5
   grp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_PRIM && wd_lo[P_TXOK] && ev_txok == '0) |=> (txok_q == '0));
   // R3
   w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_SEC0 && ev_txok == '0) |=> (txok_q == ($past(txok_q) & ~$past(wd_lo))));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NQ(NQ), .PW(PW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .wd_lo(wdata[NQ-1:0]), .ev_txok(ev_txok), .txok_q(sec_q[0][NQ-1:0]),
   .prim(prim), .pmask_q(pmask_q), .gen_q(gen_q), .irq(irq)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
   localparam int NQ = 10, DW = 32, ND = 6, PW = 10 + ND;

   logic clk = 0, rst_n = 0;
   logic wr_en = 0;
   logic [3:0] addr = 0;
   logic [DW-1:0] wdata = 0, rdata;
   logic [NQ-1:0] ev_txok = 0, ev_txdesc = 0, ev_txerr = 0, ev_eol = 0,
                  ev_urn = 0, ev_cbro = 0, ev_cbru = 0, ev_qtrig = 0;
   logic [2:0] ev_host = 0;
   logic [5:0] ev_bcn = 0;
   logic [ND-1:0] ev_direct = 0;
   logic irq;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;  // 250 MHz

   irq_aggregator #(.NQ(NQ), .DW(DW), .ND(ND)) u_dut (.*);

   function automatic int g_addr(input int g);
      int t[8] = '{1, 1, 2, 2, 3, 4, 4, 5};
      return t[g];
   endfunction
   function automatic int g_off(input int g);
      int t[8] = '{0, 16, 0, 16, 0, 0, 16, 0};
      return t[g];
   endfunction
   function automatic int g_pos(input int g);
      return (g < 5) ? g : g + 2;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [DW-1:0] v);
      addr = 4'(a); #1; v = rdata;
   endtask

   // one clock: optional write, optional per-queue event (g<0: none)
   task automatic step(input bit w, input int a, input logic [DW-1:0] d,
                       input int g, input int q);
      wr_en = w; addr = 4'(a); wdata = d;
      case (g)
         0: ev_txok[q] = 1;   1: ev_txdesc[q] = 1;
         2: ev_txerr[q] = 1;  3: ev_eol[q] = 1;
         4: ev_urn[q] = 1;    5: ev_cbro[q] = 1;
         6: ev_cbru[q] = 1;   7: ev_qtrig[q] = 1;
         default: ;
      endcase
      @(posedge clk); #1;
      wr_en = 0; ev_txok = 0; ev_txdesc = 0; ev_txerr = 0; ev_eol = 0;
      ev_urn = 0; ev_cbro = 0; ev_cbru = 0; ev_qtrig = 0;
      ev_host = 0; ev_bcn = 0; ev_direct = 0;
   endtask

   initial begin
      #200000;
      n_fail++; n_chk++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      for (int a = 0; a < 10; a++) begin rd(a, v); check("R1", v, 0); end
      check("R1 irq", DW'(irq), 0);

      // R2 R3 R4 sweep over every per-queue group and queue
      for (int g = 0; g < 8; g++)
         for (int q = 0; q < NQ; q++) begin
            step(0, 0, 0, g, q);
            rd(g_addr(g), v); check("R2", v, DW'(1) << (g_off(g) + q));
            rd(0, v);         check("R4 set", v, DW'(1) << g_pos(g));
            step(1, g_addr(g), ~(DW'(1) << (g_off(g) + q)), -1, 0);
            rd(g_addr(g), v); check("R3 keep", v, DW'(1) << (g_off(g) + q));
            step(1, g_addr(g), DW'(1) << (g_off(g) + q), -1, 0);
            rd(g_addr(g), v); check("R3 clr", v, 0);
            rd(0, v);         check("R4 drop", v, 0);
         end

      // R7 host and beacon causes gated by secondary mask
      for (int i = 0; i < 9; i++) begin
         if (i < 3) ev_host[i] = 1; else ev_bcn[i-3] = 1;
         step(0, 0, 0, -1, 0);
         rd(3, v); check("R2 R7", v, DW'(1) << (i < 3 ? 16 + i : 20 + i - 3));
         rd(0, v); check("R7 masked", v, 0);
         step(1, 7, DW'(1) << i, -1, 0);
         rd(0, v); check("R7 enabled", v, DW'(1) << (i < 3 ? 5 : 6));
         step(1, 0, DW'(1) << (i < 3 ? 5 : 6), -1, 0);
         rd(3, v); check("R5 host/bcn group", v, 0);
         step(1, 7, 0, -1, 0);
      end

      // R5 group clear leaves other groups
      ev_txok = 10'b10_0000_1001; ev_txerr[2] = 1; ev_txdesc[4] = 1;
      step(0, 0, 0, -1, 0);
      step(1, 0, 32'h1, -1, 0);
      rd(1, v); check("R5 txok cleared", v, 32'h0010_0000);
      rd(2, v); check("R5 other group kept", v, 32'h4);
      step(1, 0, 32'h6, -1, 0);
      rd(0, v); check("R5 all clear", v, 0);

      // R6 direct bits
      ev_direct = 6'b100101;
      step(0, 0, 0, -1, 0);
      rd(0, v); check("R6 set", v, 32'h9400);
      step(1, 0, 32'h0400, -1, 0);
      rd(0, v); check("R6 w1c", v, 32'h9000);
      step(1, 0, 32'h9000, -1, 0);

      // R8 interrupt gating
      step(1, 6, 32'h1, 0, 3);
      check("R8 gen off", DW'(irq), 0);
      step(1, 8, 32'h1, -1, 0);
      check("R8 on", DW'(irq), 1);
      step(1, 6, 32'h2, -1, 0);
      check("R8 pmask off", DW'(irq), 0);
      step(1, 6, 32'h1, -1, 0);
      step(1, 1, 32'h8, -1, 0);
      check("R8 cleared", DW'(irq), 0);

      // R9 event wins over direct and group clears
      step(0, 0, 0, 0, 5);
      step(1, 1, 32'h20, 0, 5);
      rd(1, v); check("R9 direct clr", v, 32'h20);
      step(0, 0, 0, 0, 7);
      step(1, 0, 32'h1, 0, 5);
      rd(1, v); check("R9 group clr", v, 32'h20);
      check("R9 irq", DW'(irq), 1);

      // R10 readback widths
      step(1, 6, '1, -1, 0); rd(6, v); check("R10 pmask", v, (DW'(1) << PW) - 1);
      step(1, 7, '1, -1, 0); rd(7, v); check("R10 smask", v, 32'h1FF);
      step(1, 8, '1, -1, 0); rd(8, v); check("R10 gen", v, 32'h1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule